// File: doc/BRIEF.md
# NAND Sector Hamming Code Generator

This block builds the error-correction code for a 512-byte NAND sector while the bytes stream past on an 8-bit bus. Each byte marked by the valid strobe is counted. Bytes 0 to 255 feed the first code and bytes 256 to 511 feed the second. Each code is three bytes wide. It holds a set of line parities taken over the byte address bits and a set of column parities taken over the bit positions within the byte. When a stored code and a freshly computed code are XORed, a single flipped bit points to its own byte address and bit position.

A one-cycle clear strobe comes from a register write. It wipes all accumulated parity and restarts counting at the first block. Once 512 bytes have been counted, the block holds its results and ignores further bytes until the next clear or reset. Both codes are always visible on one output vector, so software can read them as six byte registers.

Top module: `nand_ecc_gen`

## Requirements
- R1: After rst_ni is released, every bit of codes_o reads 0.
- R2: A cycle with clr_i high zeroes all code bits by the next cycle and restarts the byte count at block 0, whatever the current count.
- R3: Line parity bit 2k (or 2k+1) of a block is the XOR of all data bits in that block's bytes whose in-block address bit k is 0 (or 1), for k = 0..7.
- R4: Column parity bit 2j (or 2j+1) is the XOR, over all bytes of the block, of the data bits whose bit index has bit j equal to 0 (or 1), for j = 0..2.
- R5: Each 24-bit code is packed as follows. Bits [23:16] hold line parity 15..8, bits [15:8] hold line parity 7..0, bits [7:2] hold column parity 5..0 and bits [1:0] hold the two filler bits. Block 0 sits at codes_o[23:0] and block 1 at codes_o[47:24].
- R6: A block's two filler bits read 2'b00 until all 256 of its bytes are counted, and 2'b11 from the cycle after its last byte.
- R7: Bytes 0..255 after a clear change only block 0. Bytes 256..511 change only block 1.
- R8: After 512 bytes have been counted, further valid bytes change no output.
- R9: A cycle with valid_i low changes no output and does not advance the byte count.
- R10: Take two streams that differ in one bit. The XOR of their codes for the affected block has line bits 15,13,..,1 equal to the byte's in-block address and column bits 5,3,1 equal to the bit index. The other block's codes are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear strobe from a register write |
| valid_i | input | 1 | Data byte valid |
| data_i | input | 8 | Data byte |
| codes_o | output | 48 | Both codes. Block 0 in [23:0], block 1 in [47:24] |

## Verification
Every parity bit is a running XOR register, so a wrong internal state stays wrong for the rest of the sector. It shows at codes_o one cycle after the byte that caused it, and it is compared against a bit-level model at the end of each stream. A byte counter that is off by one routes a byte to the wrong block or the wrong line pair. That shows up in the literal single-byte code, in the filler bits sampled at bytes 100 and 256, and in the single-bit-flip locator. A counter that fails to stop or to restart is exposed by the extra bytes sent after byte 512 and by the mid-sector clear.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BLK_BYTES = 256;
  localparam int unsigned NUM_BLK   = 2;
endpackage

// File: rtl/ecc_byte_cnt.sv
module ecc_byte_cnt #(
  parameter int unsigned AW      = 8,
  parameter int unsigned NUM_BLK = 2,
  localparam int unsigned BW     = $clog2(NUM_BLK),
  localparam int unsigned CNTW   = AW + BW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               valid_i,
  output logic               accept_o,
  output logic [AW-1:0]      addr_o,
  output logic [BW-1:0]      blk_o,
  output logic [NUM_BLK-1:0] done_o
);
  logic [CNTW-1:0] cnt_q;
  logic [BW:0]     nblk;

  // top bit set means the whole sector has been counted
  assign accept_o = valid_i & ~cnt_q[CNTW-1];
  assign addr_o   = cnt_q[AW-1:0];
  assign blk_o    = cnt_q[AW +: BW];
  assign nblk     = cnt_q[CNTW-1:AW];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_done
    assign done_o[b] = nblk > (BW+1)'(b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (accept_o) cnt_q <= cnt_q + CNTW'(1);
  end
endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned AW     = 8,
  localparam int unsigned CW    = $clog2(BYTE_W),
  localparam int unsigned LW    = 2 * AW,
  localparam int unsigned PW    = 2 * CW,
  localparam int unsigned CODE_W = LW + PW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              done_i,
  output logic [CODE_W-1:0] code_o
);
  logic [LW-1:0] line_q, line_d;
  logic [PW-1:0] col_q, col_d;
  logic [CW-1:0][BYTE_W-1:0] hi_mask;
  logic byte_par;

  assign byte_par = ^data_i;

  // bit-index masks: hi_mask[j][i] set when bit j of index i is 1
  for (genvar j = 0; j < CW; j++) begin : g_mask
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      localparam bit SIDE = ((i >> j) & 1) == 1;
      assign hi_mask[j][i] = SIDE;
    end
  end

  for (genvar k = 0; k < AW; k++) begin : g_line
    assign line_d[2*k]   = line_q[2*k]   ^ (byte_par & ~addr_i[k]);
    assign line_d[2*k+1] = line_q[2*k+1] ^ (byte_par &  addr_i[k]);
  end

  for (genvar j = 0; j < CW; j++) begin : g_col
    assign col_d[2*j]   = col_q[2*j]   ^ (^(data_i & ~hi_mask[j]));
    assign col_d[2*j+1] = col_q[2*j+1] ^ (^(data_i &  hi_mask[j]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (clr_i) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (en_i) begin
      line_q <= line_d;
      col_q  <= col_d;
    end
  end

  assign code_o = {line_q, col_q, {2{done_i}}};
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int unsigned BYTE_W    = nand_ecc_pkg::BYTE_W,
  parameter int unsigned BLK_BYTES = nand_ecc_pkg::BLK_BYTES,
  parameter int unsigned NUM_BLK   = nand_ecc_pkg::NUM_BLK,
  localparam int unsigned AW       = $clog2(BLK_BYTES),
  localparam int unsigned BW       = $clog2(NUM_BLK),
  localparam int unsigned CODE_W   = 2 * AW + 2 * $clog2(BYTE_W) + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      valid_i,
  input  logic [BYTE_W-1:0]         data_i,
  output logic [NUM_BLK*CODE_W-1:0] codes_o
);
  logic               accept;
  logic [AW-1:0]      addr;
  logic [BW-1:0]      blk;
  logic [NUM_BLK-1:0] done;

  ecc_byte_cnt #(.AW(AW), .NUM_BLK(NUM_BLK)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .valid_i  (valid_i),
    .accept_o (accept),
    .addr_o   (addr),
    .blk_o    (blk),
    .done_o   (done)
  );

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    ecc_parity_acc #(.BYTE_W(BYTE_W), .AW(AW)) i_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (accept && (blk == BW'(b))),
      .addr_i (addr),
      .data_i (data_i),
      .done_i (done[b]),
      .code_o (codes_o[b*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int unsigned NUM_BLK = 2,
  parameter int unsigned CODE_W  = 24
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      clr_i,
  input logic                      valid_i,
  input logic [NUM_BLK*CODE_W-1:0] codes_o
);
  localparam int unsigned LAST = (NUM_BLK - 1) * CODE_W;

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> codes_o == '0);

  a_r6_filler_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codes_o[1] == codes_o[0] && codes_o[LAST+1] == codes_o[LAST]);

  a_r6_block_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codes_o[LAST] |-> codes_o[0]);

  a_r7_first_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (codes_o[0] && !clr_i) |=> $stable(codes_o[CODE_W-1:0]));

  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (codes_o[LAST] && !clr_i) |=> $stable(codes_o));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(codes_o));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.NUM_BLK(NUM_BLK), .CODE_W(CODE_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .valid_i (valid_i),
  .codes_o (codes_o)
);

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {pattern kind, seed}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_00, 12'h0_A5, 12'h1_3C, 12'h2_07, 12'h3_5B, 12'h3_E1
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [47:0] codes_o;
  logic [7:0] pat [512];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_gen i_nand_ecc_gen (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i),
    .valid_i(valid_i), .data_i(data_i), .codes_o(codes_o)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input int base);
    logic [15:0] line = '0;
    logic [5:0] col = '0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 8; b++)
        if (pat[base+a][b]) begin
          for (int k = 0; k < 8; k++) line[2*k + ((a >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) col[2*j + ((b >> j) & 1)] ^= 1'b1;
        end
    return {line, col, 2'b11};
  endfunction

  task automatic fill(input logic [3:0] kind, input logic [7:0] seed);
    for (int i = 0; i < 512; i++)
      case (kind)
        4'h0: pat[i] = seed;
        4'h1: pat[i] = 8'(i) ^ seed;
        4'h2: pat[i] = 8'(i * seed + (i >> 8));
        default: pat[i] = 8'((i * 37 + seed) ^ (i >> 3) ^ (i * i));
      endcase
  endtask

  task automatic send(input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk); valid_i = 1'b1; data_i = pat[i];
    end
    @(negedge clk); valid_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  initial begin
    logic [47:0] ref_codes, held;
    logic [23:0] diff;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset low", codes_o[23:0], 24'h0);
    check("R1 reset high", codes_o[47:24], 24'h0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      fill(VEC[v][11:8], VEC[v][7:0]);
      clear();
      send(0, 512);
      check("R3 R4 R7 block0", codes_o[23:0], model(0));
      check("R3 R4 R7 block1", codes_o[47:24], model(256));
    end

    // R5 literal packing: byte 0x80 at address 0x5A
    fill(4'h0, 8'h00);
    pat[8'h5A] = 8'h80;
    clear();
    send(0, 512);
    check("R5 packing block0", codes_o[23:0], 24'h6699AB);
    check("R5 packing block1", codes_o[47:24], 24'h000003);

    // R6 filler bits across the sector
    fill(4'h3, 8'h11);
    clear();
    send(0, 100);
    check("R6 block0 filler mid", {22'h0, codes_o[1:0]}, 24'h0);
    send(100, 256);
    check("R6 block0 filler done", {22'h0, codes_o[1:0]}, 24'h3);
    check("R6 block1 filler open", {22'h0, codes_o[25:24]}, 24'h0);
    // R9: idle cycles with moving data
    held = codes_o;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); valid_i = 1'b0; data_i = 8'(i * 29 + 3);
    end
    @(negedge clk);
    check("R9 idle low", codes_o[23:0], held[23:0]);
    check("R9 idle high", codes_o[47:24], held[47:24]);
    send(256, 512);
    check("R9 R7 block0 after gap", codes_o[23:0], model(0));
    check("R9 block1 after gap", codes_o[47:24], model(256));

    // R8: bytes past the sector end
    held = codes_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); valid_i = 1'b1; data_i = 8'(i * 13 + 1);
    end
    @(negedge clk); valid_i = 1'b0;
    check("R8 overflow low", codes_o[23:0], held[23:0]);
    check("R8 overflow high", codes_o[47:24], held[47:24]);

    // R2: clear in mid sector, then restart from block 0
    fill(4'h2, 8'h33);
    clear();
    send(0, 300);
    clear();
    check("R2 cleared low", codes_o[23:0], 24'h0);
    check("R2 cleared high", codes_o[47:24], 24'h0);
    send(0, 512);
    check("R2 restart block0", codes_o[23:0], model(0));
    check("R2 restart block1", codes_o[47:24], model(256));

    // R10: single bit flip at sector byte 300 (block 1 address 44), bit 5
    ref_codes = codes_o;
    pat[300][5] = ~pat[300][5];
    clear();
    send(0, 512);
    diff = codes_o[47:24] ^ ref_codes[47:24];
    check("R10 address", {16'h0, diff[23], diff[21], diff[19], diff[17],
                          diff[15], diff[13], diff[11], diff[9]}, 24'd44);
    check("R10 bit", {21'h0, diff[7], diff[5], diff[3]}, 24'd5);
    check("R10 other block", codes_o[23:0] ^ ref_codes[23:0], 24'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule